// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits at the issue point of an in-order pipeline that can start two instructions per cycle. Each cycle it looks at the two oldest decoded instructions. Slot 0 holds the older one and slot 1 the younger. It decides whether both may start together, whether only the older may start, or whether nothing may start. The decision comes from per-class rules that depend on age. A class may be allowed as the leader of a pair, as the follower, as either, or only on its own. The test is not simply whether two operations are independent.

Each instruction arrives as a 4-bit class code. A load/store also carries a register transfer count. A long load/store multiple occupies issue slots for more than one cycle, so the block keeps a small reservation that blocks new grants until those slots are free again. When the younger instruction is refused, it is expected to be presented again as the older one in the next cycle. Operand hazards, busy tracking of execution units and fetch are outside this block. An external stall input blocks all issue.

Top module: `dual_issue_pairer`

## Requirements
- R1: The younger slot is granted only in a cycle where the older slot is also granted. `issue_count` always equals the number of grants asserted (0, 1 or 2).
- R2: No grant is given while `stall` is high or while the older slot is not valid, whatever the younger slot carries.
- R3: Class codes 0 (direct branch) and 1 (call) are both branch-class. Two branch-class instructions never pair. A call in the older slot always issues alone.
- R4: A direct branch pairs both as the older instruction and as the younger one, for example with an immediate ALU instruction (class 2).
- R5: An immediate ALU instruction (class 2) may take either slot. A register-operand ALU instruction (class 3) pairs only as the older instruction, and only when the younger one is class 2.
- R6: Shifted-operand ALU (4), multiply (5), divide (6), floating-point (8) and vector (9) instructions always issue alone. As the older instruction each issues by itself. As the younger instruction each is refused.
- R7: A load/store (class 7) with a transfer count of 0, 1 or 2 uses a single slot and may pair as either the older or the younger instruction.
- R8: A load/store with a transfer count of 3 or more issues alone. In the following cycles it holds slots for ceil(count/2)-1 cycles. `held` bit 0 marks the older slot and bit 1 the younger slot. Every hold cycle shows `held` = 2'b11, except the last hold cycle of an odd count, which shows 2'b01. The countdown continues during `stall`.
- R9: While `held` is non-zero, no instruction is granted.
- R10: While synchronous reset `rst` is high, no grant is given. After a reset edge, `held` reads 2'b00.
- R11: Unassigned class codes (10 to 15) issue alone as the older instruction and are refused as the younger instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Blocks every grant this cycle |
| s0_valid | input | 1 | Older slot holds an instruction |
| s0_class | input | 4 | Class code of the older instruction |
| s0_xfer | input | XFER_W | Transfer count of the older instruction (load/store only) |
| s1_valid | input | 1 | Younger slot holds an instruction |
| s1_class | input | 4 | Class code of the younger instruction |
| s1_xfer | input | XFER_W | Transfer count of the younger instruction (load/store only) |
| grant0 | output | 1 | Older instruction issues this cycle |
| grant1 | output | 1 | Younger instruction issues this cycle |
| issue_count | output | 2 | Number of instructions issued this cycle |
| held | output | 2 | Slots held by an earlier long load/store (bit 0 older, bit 1 younger) |

## Verification
The assertions assume that `rst` is high from time zero until at least one clock edge has passed. They also assume that the inputs are steady around the rising edge, so grants settle before the reservation registers sample them. The stimulus meets both assumptions: it holds reset for two edges before it checks anything, and it changes every input on the falling edge. A long load/store is presented only when the bench's own reservation count is zero, and one case deliberately offers a new one while slots are held. Reset is also raised in the middle of a reservation. In that cycle `held` still shows the old value, and after the edge it reads zero.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;

    localparam int CLASS_W   = 4;
    localparam int NUM_SLOTS = 2;

    typedef enum logic [CLASS_W-1:0] {
        IC_BRANCH    = 4'd0,
        IC_CALL      = 4'd1,
        IC_ALU_IMM   = 4'd2,
        IC_ALU_REG   = 4'd3,
        IC_ALU_SHIFT = 4'd4,
        IC_MUL       = 4'd5,
        IC_DIV       = 4'd6,
        IC_LDST      = 4'd7,
        IC_FP        = 4'd8,
        IC_VEC       = 4'd9
    } iclass_e;

    // Decoded pairing attributes of one slot.
    typedef struct packed {
        logic branchy;    // branch or call
        logic imm_alu;    // immediate ALU
        logic reg_alu;    // register-operand ALU
        logic long_mem;   // multi-cycle load/store multiple
        logic lead_ok;    // may be the older member of a pair
        logic follow_ok;  // may be the younger member of a pair
    } slot_attr_t;

    function automatic logic may_lead(input logic [CLASS_W-1:0] c, input logic long_m);
        case (c)
            IC_BRANCH, IC_ALU_IMM, IC_ALU_REG: may_lead = 1'b1;
            IC_LDST:                           may_lead = !long_m;
            default:                           may_lead = 1'b0;
        endcase
    endfunction

    function automatic logic may_follow(input logic [CLASS_W-1:0] c, input logic long_m);
        case (c)
            IC_BRANCH, IC_CALL, IC_ALU_IMM: may_follow = 1'b1;
            IC_LDST:                        may_follow = !long_m;
            default:                        may_follow = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/slot_decode.sv
module slot_decode
    import dual_issue_pkg::*;
#(
    parameter int XFER_W = 3
) (
    input  logic [CLASS_W-1:0] cls,
    input  logic [XFER_W-1:0]  xfer,
    output slot_attr_t         attr
);
    localparam int LONG_MIN = 3;

    logic long_m;

    always_comb begin
        long_m         = (cls == IC_LDST) && (int'(xfer) >= LONG_MIN);
        attr.branchy   = (cls == IC_BRANCH) || (cls == IC_CALL);
        attr.imm_alu   = (cls == IC_ALU_IMM);
        attr.reg_alu   = (cls == IC_ALU_REG);
        attr.long_mem  = long_m;
        attr.lead_ok   = may_lead(cls, long_m);
        attr.follow_ok = may_follow(cls, long_m);
    end
endmodule

// File: rtl/pair_rules.sv
module pair_rules
    import dual_issue_pkg::*;
(
    input  logic       block,
    input  logic       v_old,
    input  logic       v_young,
    input  slot_attr_t a_old,
    input  slot_attr_t a_young,
    output logic       g_old,
    output logic       g_young
);
    logic pair_ok;

    always_comb begin
        pair_ok = a_old.lead_ok && a_young.follow_ok
                  && !(a_old.branchy && a_young.branchy)
                  && (!a_old.reg_alu || a_young.imm_alu);
        g_old   = v_old && !block;
        g_young = g_old && v_young && pair_ok;
    end
endmodule

// File: rtl/lsm_reservation.sv
module lsm_reservation #(
    parameter int XFER_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [XFER_W-1:0] xfer,
    output logic [1:0]        held
);
    localparam int CNT_W = XFER_W;

    logic [CNT_W-1:0] remain_q;
    logic             odd_q;
    logic [XFER_W:0]  pairs;

    always_comb begin
        pairs = ({1'b0, xfer} + 1'b1) >> 1;
        if (remain_q == '0)
            held = 2'b00;
        else if (remain_q == CNT_W'(1) && odd_q)
            held = 2'b01;
        else
            held = 2'b11;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
            odd_q    <= 1'b0;
        end else if (start) begin
            remain_q <= CNT_W'(pairs - 1'b1);
            odd_q    <= xfer[0];
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assert_long_reserves_R8: assert property (@(posedge clk) disable iff (rst)
        start |=> (held != 2'b00));

    assert_odd_tail_frees_R8: assert property (@(posedge clk) disable iff (rst)
        (held == 2'b01) |=> (held == 2'b00));
endmodule

// File: rtl/dual_issue_pairer.sv
module dual_issue_pairer
    import dual_issue_pkg::*;
#(
    parameter int XFER_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stall,
    input  logic               s0_valid,
    input  logic [CLASS_W-1:0] s0_class,
    input  logic [XFER_W-1:0]  s0_xfer,
    input  logic               s1_valid,
    input  logic [CLASS_W-1:0] s1_class,
    input  logic [XFER_W-1:0]  s1_xfer,
    output logic               grant0,
    output logic               grant1,
    output logic [1:0]         issue_count,
    output logic [1:0]         held
);
    logic [NUM_SLOTS-1:0][CLASS_W-1:0] cls_arr;
    logic [NUM_SLOTS-1:0][XFER_W-1:0]  xfer_arr;
    slot_attr_t                        attr [NUM_SLOTS];
    logic                              block;

    assign cls_arr  = {s1_class, s0_class};
    assign xfer_arr = {s1_xfer, s0_xfer};

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_dec
        slot_decode #(.XFER_W(XFER_W)) u_dec (
            .cls  (cls_arr[i]),
            .xfer (xfer_arr[i]),
            .attr (attr[i])
        );
    end

    assign block = rst || stall || (held != 2'b00);

    pair_rules u_rules (
        .block   (block),
        .v_old   (s0_valid),
        .v_young (s1_valid),
        .a_old   (attr[0]),
        .a_young (attr[1]),
        .g_old   (grant0),
        .g_young (grant1)
    );

    assign issue_count = {1'b0, grant0} + {1'b0, grant1};

    lsm_reservation #(.XFER_W(XFER_W)) u_resv (
        .clk   (clk),
        .rst   (rst),
        .start (grant0 && attr[0].long_mem),
        .xfer  (s0_xfer),
        .held  (held)
    );

    assert_young_needs_old_R1: assert property (@(posedge clk) disable iff (rst)
        grant1 |-> grant0);

    assert_stall_blocks_R2: assert property (@(posedge clk) disable iff (rst)
        stall |-> !(grant0 || grant1));

    assert_no_branch_pair_R3: assert property (@(posedge clk) disable iff (rst)
        grant1 |-> !((s0_class <= IC_CALL) && (s1_class <= IC_CALL)));

    assert_hold_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        (held != 2'b00) |-> !grant0);
endmodule

// File: tb/tb_dual_issue_pairer.sv
module tb_dual_issue_pairer;
    localparam int CLK_P  = 10;
    localparam int XFER_W = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stall = 1'b0;
    logic s0_valid = 1'b0, s1_valid = 1'b0;
    logic [3:0] s0_class = '0, s1_class = '0;
    logic [XFER_W-1:0] s0_xfer = '0, s1_xfer = '0;
    logic grant0, grant1;
    logic [1:0] issue_count, held;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        bit       g0;
        bit       g1;
        bit [1:0] cnt;
        bit [1:0] hld;
        string    tag;
    } exp_t;
    exp_t q[$];

    int m_rem = 0;
    bit m_odd = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    dual_issue_pairer #(.XFER_W(XFER_W)) dut (
        .clk(clk), .rst(rst), .stall(stall),
        .s0_valid(s0_valid), .s0_class(s0_class), .s0_xfer(s0_xfer),
        .s1_valid(s1_valid), .s1_class(s1_class), .s1_xfer(s1_xfer),
        .grant0(grant0), .grant1(grant1), .issue_count(issue_count), .held(held)
    );

    function automatic bit lead(input int c, input int x);
        if (c == 0 || c == 2 || c == 3) return 1'b1;
        if (c == 7) return x < 3;
        return 1'b0;
    endfunction

    function automatic bit follow(input int c, input int x);
        if (c == 0 || c == 1 || c == 2) return 1'b1;
        if (c == 7) return x < 3;
        return 1'b0;
    endfunction

    task automatic step(input bit r, input bit st,
                        input bit v0, input int c0, input int x0,
                        input bit v1, input int c1, input int x1,
                        input string tag);
        exp_t e;
        bit pr;
        @(negedge clk);
        rst = r; stall = st;
        s0_valid = v0; s0_class = 4'(c0); s0_xfer = XFER_W'(x0);
        s1_valid = v1; s1_class = 4'(c1); s1_xfer = XFER_W'(x1);
        e.hld = (m_rem == 0) ? 2'b00 : ((m_rem == 1 && m_odd) ? 2'b01 : 2'b11);
        pr = lead(c0, x0) && follow(c1, x1) && !(c0 <= 1 && c1 <= 1)
             && (c0 != 3 || c1 == 2);
        e.g0  = v0 && !r && !st && (e.hld == 2'b00);
        e.g1  = e.g0 && v1 && pr;
        e.cnt = 2'(int'(e.g0) + int'(e.g1));
        e.tag = tag;
        q.push_back(e);
        if (r) begin
            m_rem = 0; m_odd = 1'b0;
        end else if (e.g0 && c0 == 7 && x0 >= 3) begin
            m_rem = (x0 + 1) / 2 - 1; m_odd = x0[0];
        end else if (m_rem > 0) begin
            m_rem = m_rem - 1;
        end
    endtask

    // Monitor: compare a quarter period after each falling edge.
    always @(negedge clk) begin
        #(CLK_P/4);
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (grant0 !== e.g0 || grant1 !== e.g1 || issue_count !== e.cnt || held !== e.hld) begin
                n_bad++;
                $display("FAIL %s: got g0=%0b g1=%0b cnt=%0d held=%b, expected g0=%0b g1=%0b cnt=%0d held=%b",
                         e.tag, grant0, grant1, issue_count, held, e.g0, e.g1, e.cnt, e.hld);
            end
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R10 reset
        step(1, 0, 1, 2, 0, 1, 2, 0, "R10 grants off in reset");
        // R2
        step(0, 0, 0, 2, 0, 1, 2, 0, "R2 older invalid");
        step(0, 1, 1, 2, 0, 1, 2, 0, "R2 stall");
        // R1 single valid
        step(0, 0, 1, 2, 0, 0, 2, 0, "R1 only older valid");
        // R4
        step(0, 0, 1, 0, 0, 1, 2, 0, "R4 branch leads");
        step(0, 0, 1, 2, 0, 1, 0, 0, "R4 branch follows");
        // R3
        step(0, 0, 1, 0, 0, 1, 0, 0, "R3 branch+branch");
        step(0, 0, 1, 0, 0, 1, 1, 0, "R3 branch+call");
        step(0, 0, 1, 1, 0, 1, 2, 0, "R3 call older alone");
        step(0, 0, 1, 2, 0, 1, 1, 0, "R3 call as younger");
        // R5
        step(0, 0, 1, 2, 0, 1, 2, 0, "R5 imm+imm");
        step(0, 0, 1, 3, 0, 1, 2, 0, "R5 reg+imm");
        step(0, 0, 1, 3, 0, 1, 3, 0, "R5 reg+reg");
        step(0, 0, 1, 2, 0, 1, 3, 0, "R5 imm+reg");
        step(0, 0, 1, 3, 0, 1, 0, 0, "R5 reg+branch");
        // R6
        for (int c = 4; c <= 9; c++) begin
            if (c == 7) continue;
            step(0, 0, 1, c, 0, 1, 2, 0, "R6 single class older");
            step(0, 0, 1, 2, 0, 1, c, 0, "R6 single class younger");
        end
        // R7
        step(0, 0, 1, 7, 1, 1, 2, 0, "R7 ld1 leads");
        step(0, 0, 1, 2, 0, 1, 7, 2, "R7 ld2 follows");
        step(0, 0, 1, 7, 0, 1, 7, 2, "R7 ld0+ld2");
        step(0, 0, 1, 2, 0, 1, 7, 3, "R7 long younger refused");
        // R8/R9 count 3: one hold cycle on older slot
        step(0, 0, 1, 7, 3, 1, 2, 0, "R8 ld3 alone");
        step(0, 0, 1, 0, 0, 1, 2, 0, "R9 blocked under 01 hold");
        step(0, 0, 1, 0, 0, 1, 2, 0, "R8 free after ld3");
        // count 4: one cycle both slots
        step(0, 0, 1, 7, 4, 1, 2, 0, "R8 ld4 alone");
        step(0, 0, 1, 7, 4, 1, 2, 0, "R9 new long refused under hold");
        step(0, 0, 1, 2, 0, 1, 2, 0, "R8 free after ld4");
        // count 7: 11,11,01 with stall in the middle
        step(0, 0, 1, 7, 7, 0, 2, 0, "R8 ld7 alone");
        step(0, 0, 1, 2, 0, 1, 2, 0, "R9 ld7 hold 1");
        step(0, 1, 1, 2, 0, 1, 2, 0, "R8 countdown under stall");
        step(0, 0, 1, 2, 0, 1, 2, 0, "R9 ld7 tail");
        step(0, 0, 1, 2, 0, 1, 2, 0, "R8 free after ld7");
        // count 6: 11,11
        step(0, 0, 1, 7, 6, 1, 2, 0, "R8 ld6 alone");
        step(0, 0, 1, 3, 0, 1, 2, 0, "R9 ld6 hold 1");
        step(0, 0, 1, 3, 0, 1, 2, 0, "R9 ld6 hold 2");
        step(0, 0, 1, 3, 0, 1, 2, 0, "R8 free after ld6");
        // stalled long op does not reserve
        step(0, 1, 1, 7, 5, 0, 2, 0, "R8 stalled long no start");
        step(0, 0, 1, 2, 0, 1, 2, 0, "R8 no hold after stalled long");
        // reset mid-hold (R10)
        step(0, 0, 1, 7, 5, 0, 2, 0, "R8 ld5 alone");
        step(1, 0, 1, 2, 0, 1, 2, 0, "R10 reset during hold");
        step(0, 0, 1, 2, 0, 1, 2, 0, "R10 hold cleared");
        // R11
        step(0, 0, 1, 12, 0, 1, 2, 0, "R11 unknown older");
        step(0, 0, 1, 2, 0, 1, 15, 0, "R11 unknown younger");
        step(0, 0, 1, 10, 0, 1, 0, 0, "R11 unknown+branch");
        step(0, 0, 0, 2, 0, 0, 2, 0, "R2 idle");
        @(negedge clk);
        @(negedge clk);
        if (q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R1 queue not drained: got %0d, expected 0", q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R1 watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule